// File: doc/BRIEF.md
# Accumulator Readout Formatter

This block turns a wide multiply-accumulate accumulator into a register-sized result word. It sits between the accumulator storage and the register file of a DSP-style datapath. On each move of an accumulator into a general register, it applies the number format currently chosen by the mode inputs. The accumulator is treated as a signed two's-complement value and sign-extended to a double-width intermediate before any formatting.

Three formats are offered. The integer formats clamp the accumulator into a signed or an unsigned word. The fractional format drops a fixed number of low fraction bits. It rounds half-to-even at one of two cut points and can saturate a result that no longer fits. A half-width fractional result always rounds, and its word is zero-extended. A full-width fractional result rounds only when rounding is enabled and truncates otherwise. An optional output register, chosen by parameter, gives one cycle of latency.

Top module: `acc_readout_fmt`

## Requirements
- R1: The 48-bit accumulator is a signed value: bit 47 set means negative, and it is sign-extended to a 64-bit intermediate before formatting.
- R2: `frac_i`=1 selects the fractional format whatever `uns_i` is. In fractional mode `half_i`=1 takes priority over `rnd_i`, so half-width results round even when `rnd_i`=0.
- R3: Half-width fractional mode keeps intermediate bits 39..24 as a 16-bit unsigned value and treats bits 23..0 as the remainder. It adds 1 when the remainder exceeds 0x800000, and adds the kept LSB when the remainder equals 0x800000. Output bits 31..16 are zero.
- R4: Full-width fractional mode with `rnd_i`=1 arithmetically shifts the intermediate right by 8 and treats bits 7..0 as the remainder. It adds 1 above 0x80 and adds the kept LSB at exactly 0x80.
- R5: Full-width fractional mode with `rnd_i`=0 outputs intermediate bits 39..8, which is a plain arithmetic shift right by 8.
- R6: In half-width mode with `sat_i`=1, a rounded value that no longer fits in 16 unsigned bits gives 0x7FFF. Overflow happens only when rounding carries out of bits 39..24 = 0xFFFF.
- R7: In full-width mode with `sat_i`=1, a shifted and rounded value outside the signed 32-bit range gives 0x7FFFFFFF if it is positive and 0x80000000 if it is negative.
- R8: In fractional mode with `sat_i`=0, the output is the low 16 bits (half-width) or low 32 bits (full-width) of the shifted and rounded value.
- R9: With `frac_i`=0 and `uns_i`=0, an accumulator within the signed 32-bit range passes through unchanged. Otherwise the output is 0x7FFFFFFF if the accumulator is positive and 0x80000000 if it is negative.
- R10: With `frac_i`=0 and `uns_i`=1, an accumulator in 0..0xFFFFFFFF passes through unchanged. Otherwise, negative values included, the output is 0xFFFFFFFF.
- R11: `sat_i`, `rnd_i` and `half_i` have no effect in the integer formats: integer clamping always applies.
- R12: With REG_OUT=1 (default), `word_o` is 0 while `rst_ni` is low. A new input appears on `word_o` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| acc_i | input | 48 | Signed accumulator value |
| frac_i | input | 1 | 1 = fractional format, 0 = integer format |
| uns_i | input | 1 | Integer format: 1 = unsigned clamp, 0 = signed clamp |
| half_i | input | 1 | Fractional format: 1 = 16-bit result |
| rnd_i | input | 1 | Fractional full-width: 1 = round half-to-even |
| sat_i | input | 1 | Fractional format: 1 = saturate on overflow |
| word_o | output | 32 | Formatted result word |

## Verification
The fractional paths are driven with remainders exactly at, one below and one above the half point. Both odd and even kept LSBs are used, so truncation, round-half-up and true half-to-even rounding each give a different word. Values next to the limits are also applied: a kept 0xFFFF that rounds up, a full-width 0x7FFFFFFF that rounds up, large positive and negative accumulators, and integers exactly at the signed and unsigned bounds. These show whether saturation, the sign taken for the clamp and sign extension of bit 47 are handled correctly. A sweep over every combination of the five mode inputs against a behavioural model shows that the mode priority holds and that inputs outside the active format are ignored.

// File: rtl/accfmt_pkg.sv
package accfmt_pkg;

   // Clamp variants used by the formatter's saturation stages.
   typedef enum logic [1:0] {
      CLAMP_SIGNED  = 2'd0,   // fit as signed OUT_W; limit by sign
      CLAMP_ONES    = 2'd1,   // fit as unsigned OUT_W; limit all ones
      CLAMP_SIGNSAT = 2'd2    // fit as unsigned OUT_W; limit by sign
   } clamp_e;

endpackage

// File: rtl/accfmt_round.sv
module accfmt_round #(
   parameter int WIDE_W = 64,
   parameter int CUT    = 8,
   parameter int KEEP_W = 0      // 0: keep all shifted bits; >0: mask to KEEP_W
) (
   input  logic [WIDE_W-1:0] val_i,
   input  logic              rnd_en_i,
   output logic [WIDE_W-1:0] kept_o
);

   localparam logic [CUT-1:0] HALF_REM = {1'b1, {(CUT-1){1'b0}}};

   if (CUT < 1 || CUT >= WIDE_W) begin : g_bad_cut
      $error("accfmt_round: CUT out of range");
   end
   if (KEEP_W < 0 || KEEP_W > WIDE_W - CUT) begin : g_bad_keep
      $error("accfmt_round: KEEP_W out of range");
   end

   logic [WIDE_W-1:0] shifted;
   logic [WIDE_W-1:0] base;
   logic [CUT-1:0]    rem;
   logic              bump;

   assign shifted = WIDE_W'($signed(val_i) >>> CUT);
   assign rem     = val_i[CUT-1:0];

   if (KEEP_W == 0) begin : g_full
      assign base = shifted;
   end else begin : g_mask
      localparam logic [WIDE_W-1:0] KEEP_MASK = {WIDE_W{1'b1}} >> (WIDE_W - KEEP_W);
      assign base = shifted & KEEP_MASK;
   end

   // round half to even: above half always bumps, exact half bumps odd values
   assign bump   = rnd_en_i & ((rem > HALF_REM) | ((rem == HALF_REM) & base[0]));
   assign kept_o = base + WIDE_W'(bump);

endmodule

// File: rtl/accfmt_clamp.sv
module accfmt_clamp
   import accfmt_pkg::*;
#(
   parameter int     WIDE_W = 64,
   parameter int     OUT_W  = 32,
   parameter clamp_e KIND   = CLAMP_SIGNED
) (
   input  logic [WIDE_W-1:0] val_i,
   input  logic              sat_en_i,
   output logic [OUT_W-1:0]  res_o
);

   localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

   if (OUT_W < 2 || OUT_W >= WIDE_W) begin : g_bad_w
      $error("accfmt_clamp: OUT_W out of range");
   end

   logic             fits;
   logic [OUT_W-1:0] limit;

   case (KIND)
      CLAMP_SIGNED: begin : g_signed
         logic [WIDE_W-OUT_W:0] top;
         assign top   = val_i[WIDE_W-1:OUT_W-1];
         assign fits  = (&top) | ~(|top);
         assign limit = val_i[WIDE_W-1] ? NEG_LIM : POS_LIM;
      end
      CLAMP_ONES: begin : g_ones
         assign fits  = ~(|val_i[WIDE_W-1:OUT_W]);
         assign limit = '1;
      end
      default: begin : g_signsat
         assign fits  = ~(|val_i[WIDE_W-1:OUT_W]);
         assign limit = val_i[WIDE_W-1] ? NEG_LIM : POS_LIM;
      end
   endcase

   assign res_o = (sat_en_i & ~fits) ? limit : val_i[OUT_W-1:0];

endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt
   import accfmt_pkg::*;
#(
   parameter int ACC_W    = 48,
   parameter int OUT_W    = 32,
   parameter int HALF_W   = 16,
   parameter int HALF_CUT = 24,
   parameter int FULL_CUT = 8,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ACC_W-1:0] acc_i,
   input  logic             frac_i,
   input  logic             uns_i,
   input  logic             half_i,
   input  logic             rnd_i,
   input  logic             sat_i,
   output logic [OUT_W-1:0] word_o
);

   localparam int WIDE_W = 2 * OUT_W;

   if (ACC_W <= OUT_W || ACC_W > WIDE_W) begin : g_bad_acc
      $error("acc_readout_fmt: ACC_W must lie in (OUT_W, 2*OUT_W]");
   end
   if (HALF_W >= OUT_W || HALF_CUT + HALF_W > ACC_W) begin : g_bad_half
      $error("acc_readout_fmt: half-width cut does not fit the accumulator");
   end
   if (FULL_CUT + OUT_W > WIDE_W) begin : g_bad_full
      $error("acc_readout_fmt: full-width cut too large");
   end

   logic [WIDE_W-1:0] wide;
   logic [WIDE_W-1:0] half_kept, full_kept;
   logic [HALF_W-1:0] half_res;
   logic [OUT_W-1:0]  full_res, sint_res, uint_res;
   logic [OUT_W-1:0]  frac_word, int_word, word_d;

   assign wide = {{(WIDE_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};

   // half-width path always rounds; full-width path rounds on request
   accfmt_round #(.WIDE_W(WIDE_W), .CUT(HALF_CUT), .KEEP_W(HALF_W)) half_rnd_i (
      .val_i(wide), .rnd_en_i(1'b1), .kept_o(half_kept));

   accfmt_round #(.WIDE_W(WIDE_W), .CUT(FULL_CUT), .KEEP_W(0)) full_rnd_i (
      .val_i(wide), .rnd_en_i(rnd_i), .kept_o(full_kept));

   accfmt_clamp #(.WIDE_W(WIDE_W), .OUT_W(HALF_W), .KIND(CLAMP_SIGNSAT)) half_sat_i (
      .val_i(half_kept), .sat_en_i(sat_i), .res_o(half_res));

   accfmt_clamp #(.WIDE_W(WIDE_W), .OUT_W(OUT_W), .KIND(CLAMP_SIGNED)) full_sat_i (
      .val_i(full_kept), .sat_en_i(sat_i), .res_o(full_res));

   accfmt_clamp #(.WIDE_W(WIDE_W), .OUT_W(OUT_W), .KIND(CLAMP_SIGNED)) sint_sat_i (
      .val_i(wide), .sat_en_i(1'b1), .res_o(sint_res));

   accfmt_clamp #(.WIDE_W(WIDE_W), .OUT_W(OUT_W), .KIND(CLAMP_ONES)) uint_sat_i (
      .val_i(wide), .sat_en_i(1'b1), .res_o(uint_res));

   assign frac_word = half_i ? {{(OUT_W-HALF_W){1'b0}}, half_res} : full_res;
   assign int_word  = uns_i  ? uint_res : sint_res;
   assign word_d    = frac_i ? frac_word : int_word;

   if (REG_OUT) begin : g_reg
      logic [OUT_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) word_q <= '0;
         else         word_q <= word_d;
      end
      assign word_o = word_q;
   end else begin : g_comb
      assign word_o = word_d;
   end

endmodule

// File: rtl/acc_readout_fmt_chk.sv
module acc_readout_fmt_chk #(
   parameter int ACC_W    = 48,
   parameter int OUT_W    = 32,
   parameter int FULL_CUT = 8,
   parameter bit REG_OUT  = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [ACC_W-1:0] acc_i,
   input logic             frac_i,
   input logic             uns_i,
   input logic             half_i,
   input logic             rnd_i,
   input logic             sat_i,
   input logic [OUT_W-1:0] word_o
);

   logic [ACC_W-1:0] a_acc;
   logic a_frac, a_uns, a_half, a_rnd, a_sat, a_ok;

   // align the inputs with the output they produced
   if (REG_OUT) begin : g_lat
      always_ff @(posedge clk_i) begin
         a_acc  <= acc_i;
         a_frac <= frac_i;
         a_uns  <= uns_i;
         a_half <= half_i;
         a_rnd  <= rnd_i;
         a_sat  <= sat_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) a_ok <= 1'b0;
         else         a_ok <= 1'b1;
      end
   end else begin : g_now
      assign a_acc  = acc_i;
      assign a_frac = frac_i;
      assign a_uns  = uns_i;
      assign a_half = half_i;
      assign a_rnd  = rnd_i;
      assign a_sat  = sat_i;
      assign a_ok   = 1'b1;
   end

   logic sint_fits;
   assign sint_fits = (&a_acc[ACC_W-1:OUT_W-1]) | ~(|a_acc[ACC_W-1:OUT_W-1]);

   // R10
   uint_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_ok && !a_frac && a_uns && (|a_acc[ACC_W-1:OUT_W])) |-> (word_o == '1));

   // R9
   sint_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_ok && !a_frac && !a_uns && !sint_fits) |->
      (word_o == (a_acc[ACC_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}})));

   // R11
   sint_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_ok && !a_frac && !a_uns && sint_fits) |-> (word_o == a_acc[OUT_W-1:0]));

   // R3
   half_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_ok && a_frac && a_half) |-> (word_o[OUT_W-1:OUT_W/2] == '0));

   // R5
   trunc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_ok && a_frac && !a_half && !a_rnd && !a_sat) |->
      (word_o == a_acc[FULL_CUT+OUT_W-1:FULL_CUT]));

endmodule

bind acc_readout_fmt acc_readout_fmt_chk #(
   .ACC_W(ACC_W), .OUT_W(OUT_W), .FULL_CUT(FULL_CUT), .REG_OUT(REG_OUT)
) chk_i (.*);

// File: tb/acc_readout_fmt_tb_top.sv
module acc_readout_fmt_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [47:0] acc_i = '0;
   logic        frac_i = 1'b0, uns_i = 1'b0, half_i = 1'b0, rnd_i = 1'b0, sat_i = 1'b0;
   logic [31:0] word_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   acc_readout_fmt dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .frac_i(frac_i),
      .uns_i(uns_i), .half_i(half_i), .rnd_i(rnd_i), .sat_i(sat_i), .word_o(word_o));

   localparam logic [47:0] VECS [16] = '{
      48'h001234800000, 48'h001235800000, 48'h0012347FFFFF, 48'h001234800001,
      48'h000012345680, 48'h000012345780, 48'h00001234567F, 48'h000012345681,
      48'h00FFFF800001, 48'h007FFFFFFF80, 48'h7F0000000000, 48'h800000000000,
      48'hFFFF80000000, 48'h000100000005, 48'hFFFFFFFFFF00, 48'hFF8000000000};

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic apply(input logic [47:0] a, input logic fr, us, hf, rn, st);
      @(negedge clk_i);
      acc_i = a; frac_i = fr; uns_i = us; half_i = hf; rnd_i = rn; sat_i = st;
      @(negedge clk_i);
   endtask

   // behavioural model written from the requirements
   function automatic logic [31:0] model(input logic [47:0] a, input logic fr, us, hf, rn, st);
      longint v, k, r;
      v = {{16{a[47]}}, a};
      if (fr) begin
         if (hf) begin
            k = (v >>> 24) & 64'hFFFF;
            r = v & 64'hFFFFFF;
            if (r > 64'h800000) k++;
            else if (r == 64'h800000) k += k & 1;
            if (st && k > 65535) return 32'h00007FFF;
            return {16'h0, k[15:0]};
         end
         k = v >>> 8;
         if (rn) begin
            r = v & 64'hFF;
            if (r > 128) k++;
            else if (r == 128) k += k & 1;
         end
         if (st && (k >>> 31) != 0 && (k >>> 31) != -1)
            return (k < 0) ? 32'h80000000 : 32'h7FFFFFFF;
         return k[31:0];
      end
      if (!us) begin
         if ((v >>> 31) == 0 || (v >>> 31) == -1) return v[31:0];
         return (v < 0) ? 32'h80000000 : 32'h7FFFFFFF;
      end
      if ((v >>> 32) == 0) return v[31:0];
      return 32'hFFFFFFFF;
   endfunction

   function automatic string mode_tag(input logic fr, us, hf, rn, st);
      if (!fr) return us ? "R10" : "R9";
      if (hf)  return st ? "R6" : "R3";
      if (st)  return "R7";
      return rn ? "R4" : "R5";
   endfunction

   task automatic t_reset();
      #(CLK_PERIOD/4);
      check("R12 reset", word_o, 32'h0);
      @(negedge clk_i);
      check("R12 reset held", word_o, 32'h0);
      rst_ni = 1'b1;
   endtask

   task automatic t_half_round();
      apply(48'h001234800000, 1, 0, 1, 1, 0); check("R3 half even stays", word_o, 32'h00001234);
      apply(48'h001235800000, 1, 0, 1, 1, 0); check("R3 half odd bumps", word_o, 32'h00001236);
      apply(48'h001234800001, 1, 0, 1, 1, 0); check("R3 above half", word_o, 32'h00001235);
      apply(48'h0012347FFFFF, 1, 0, 1, 1, 0); check("R3 below half", word_o, 32'h00001234);
      apply(48'hFF8000000000, 1, 0, 1, 1, 0); check("R1 negative half-width", word_o, 32'h00008000);
   endtask

   task automatic t_full_round();
      apply(48'h000012345680, 1, 0, 0, 1, 0); check("R4 half even stays", word_o, 32'h00123456);
      apply(48'h000012345780, 1, 0, 0, 1, 0); check("R4 half odd bumps", word_o, 32'h00123458);
      apply(48'h000012345681, 1, 0, 0, 1, 0); check("R4 above half", word_o, 32'h00123457);
      apply(48'h00001234567F, 1, 0, 0, 1, 0); check("R4 below half", word_o, 32'h00123456);
      apply(48'hFFFFFFFFFF00, 1, 0, 0, 1, 0); check("R1 minus one", word_o, 32'hFFFFFFFF);
   endtask

   task automatic t_trunc();
      apply(48'h0000123456FF, 1, 0, 0, 0, 0); check("R5 truncation", word_o, 32'h00123456);
      apply(48'hFFFFFFFFFEFF, 1, 0, 0, 0, 0); check("R5 negative truncation", word_o, 32'hFFFFFFFE);
   endtask

   task automatic t_sat_half();
      apply(48'h00FFFF800001, 1, 0, 1, 1, 1); check("R6 carry saturates", word_o, 32'h00007FFF);
      apply(48'h00FFFF800001, 1, 0, 1, 1, 0); check("R8 carry wraps", word_o, 32'h00000000);
   endtask

   task automatic t_sat_full();
      apply(48'h7F0000000000, 1, 0, 0, 1, 1); check("R7 positive limit", word_o, 32'h7FFFFFFF);
      apply(48'h800000000000, 1, 0, 0, 1, 1); check("R7 negative limit", word_o, 32'h80000000);
      apply(48'h7F0000000000, 1, 0, 0, 1, 0); check("R8 positive wrap", word_o, 32'h00000000);
      apply(48'h007FFFFFFF80, 1, 0, 0, 1, 1); check("R7 round into overflow", word_o, 32'h7FFFFFFF);
      apply(48'h007FFFFFFF80, 1, 0, 0, 1, 0); check("R8 round wraps", word_o, 32'h80000000);
   endtask

   task automatic t_sint();
      apply(48'h00007FFFFFFF, 0, 0, 0, 0, 0); check("R9 max passes", word_o, 32'h7FFFFFFF);
      apply(48'h000080000000, 0, 0, 0, 0, 0); check("R9 above max", word_o, 32'h7FFFFFFF);
      apply(48'hFFFF80000000, 0, 0, 0, 0, 0); check("R9 min passes", word_o, 32'h80000000);
      apply(48'hFFFF7FFFFFFF, 0, 0, 0, 0, 0); check("R9 below min", word_o, 32'h80000000);
      apply(48'hFFFFFFFFFFFE, 0, 0, 0, 0, 0); check("R9 small negative", word_o, 32'hFFFFFFFE);
   endtask

   task automatic t_uint();
      apply(48'h0000FFFFFFFF, 0, 1, 0, 0, 0); check("R10 max passes", word_o, 32'hFFFFFFFF);
      apply(48'h000100000005, 0, 1, 0, 0, 0); check("R10 above max", word_o, 32'hFFFFFFFF);
      apply(48'h000012345678, 0, 1, 0, 0, 0); check("R10 in range", word_o, 32'h12345678);
      apply(48'hFFFFFFFFFFFE, 0, 1, 0, 0, 0); check("R10 negative", word_o, 32'hFFFFFFFF);
   endtask

   task automatic t_ignore();
      apply(48'h001234800001, 1, 0, 1, 0, 0); check("R2 half rounds without rnd", word_o, 32'h00001235);
      apply(48'h001234800001, 1, 1, 1, 1, 0); check("R2 frac wins over uns", word_o, 32'h00001235);
      apply(48'h000080000000, 0, 0, 1, 1, 0); check("R11 signed clamp without sat", word_o, 32'h7FFFFFFF);
      apply(48'h000100000005, 0, 1, 1, 1, 0); check("R11 unsigned clamp without sat", word_o, 32'hFFFFFFFF);
      apply(48'h000012345681, 0, 0, 0, 1, 1); check("R11 no rounding in integer", word_o, 32'h12345681);
   endtask

   task automatic t_latency();
      apply(48'h000000000011, 0, 0, 0, 0, 0);
      @(negedge clk_i);
      acc_i = 48'h000000000022;
      #(CLK_PERIOD/4);
      check("R12 holds before edge", word_o, 32'h00000011);
      @(negedge clk_i);
      check("R12 updates after one edge", word_o, 32'h00000022);
   endtask

   task automatic t_sweep();
      for (int m = 0; m < 32; m++) begin
         for (int i = 0; i < 16; i++) begin
            logic fr, us, hf, rn, st;
            {fr, us, hf, rn, st} = m[4:0];
            apply(VECS[i], fr, us, hf, rn, st);
            check(mode_tag(fr, us, hf, rn, st), word_o, model(VECS[i], fr, us, hf, rn, st));
         end
      end
   endtask

   initial begin
      t_reset();
      t_half_round();
      t_full_round();
      t_trunc();
      t_sat_half();
      t_sat_full();
      t_sint();
      t_uint();
      t_ignore();
      t_latency();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule